// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Pair

This block performs 32-bit integer multiplication and division for a load/store RISC core. The core presents two register operands together with a one-cycle start command. The command names the operation (multiply or divide) and the sign mode (signed or unsigned). The unit then iterates one bit per clock. Multiplication uses a shift-add loop and division uses a restoring shift-subtract loop. Results go into a dedicated pair of special-purpose registers. For a product, the upper half goes to HI and the lower half to LO. For a quotient and remainder, the quotient goes to LO and the remainder to HI.

The core reads HI and LO continuously on two read ports. It can also load either register directly from a write bus through separate strobes, but only while the unit is idle. `busy_o` stays high for the whole operation. A single-cycle `done_o` marks the cycle in which HI and LO take their new values. Signed operation works on magnitudes and corrects the signs afterwards. Division by zero finishes in the normal number of cycles with a defined result.

Top module: `mdu_hilo`

## Requirements
- R1: An unsigned multiply (`op_div_i`=0, `signed_i`=0) leaves the upper 32 bits of the 64-bit product in HI and the lower 32 bits in LO.
- R2: An unsigned divide (`op_div_i`=1, `signed_i`=0) with a nonzero divisor leaves the quotient in LO and the remainder in HI.
- R3: A signed multiply (`signed_i`=1) treats both operands as two's complement and leaves the 64-bit two's-complement product split across HI (upper) and LO (lower).
- R4: A signed divide truncates the quotient toward zero (negated when the operand signs differ), and the remainder carries the sign of the dividend; dividing the most negative value by -1 yields quotient 0x80000000 and remainder 0.
- R5: Dividing by zero, in either sign mode, sets LO to 0xFFFFFFFF and HI to the original dividend, and completes with the same latency as any other operation.
- R6: For a start accepted at clock edge N, `busy_o` is high after edges N through N+32. `done_o` is high for exactly one cycle, after edge N+33, and at that same edge `busy_o` drops.
- R7: A start request while `busy_o` is high is ignored: it produces no extra `done_o` and does not change the result of the running operation.
- R8: HI and LO keep their previous values throughout an operation, and both change together at the edge that raises `done_o`.
- R9: While idle, `hi_wr_i` loads HI from `wdata_i` and `lo_wr_i` loads LO from `wdata_i` at the next edge; each strobe leaves the other register unchanged, and both may be used in the same cycle.
- R10: `hi_wr_i` and `lo_wr_i` have no effect while `busy_o` is high.
- R11: After reset, HI and LO read zero and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, taken only when idle |
| op_div_i | input | 1 | Operation select: 0 multiply, 1 divide |
| signed_i | input | 1 | Sign mode: 0 unsigned, 1 two's complement |
| opa_i | input | 32 | Multiplicand or dividend |
| opb_i | input | 32 | Multiplier or divisor |
| hi_wr_i | input | 1 | Direct write strobe for HI |
| lo_wr_i | input | 1 | Direct write strobe for LO |
| wdata_i | input | 32 | Data for direct writes |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| hi_o | output | 32 | Current HI value |
| lo_o | output | 32 | Current LO value |

## Verification
A fault in the iteration datapath or the sign correction stays hidden until the end of the operation. It then shows as a wrong HI or LO value in the `done_o` cycle, 34 cycles after the start request is driven. A miscounted step counter shifts `done_o` away from that fixed cycle, so it shows even when the values are right. A fault in the idle/busy gating shows sooner, as an HI or LO change in the middle of an operation or as a second completion pulse.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

   typedef enum logic [1:0] {
      MDU_IDLE = 2'd0,
      MDU_RUN  = 2'd1,
      MDU_FIN  = 2'd2
   } mdu_state_e;

   typedef struct packed {
      logic is_div;
      logic neg_main;
      logic neg_rem;
      logic div_zero;
   } mdu_ctl_t;

endpackage

// File: rtl/mdu_operand_prep.sv
module mdu_operand_prep #(
   parameter int WIDTH = 32
) (
   input  logic             signed_mode,
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic [WIDTH-1:0] mag_a,
   output logic [WIDTH-1:0] mag_b,
   output logic             neg_a,
   output logic             neg_b
);

   localparam logic [WIDTH-1:0] ONE_W = WIDTH'(1);

   logic [1:0][WIDTH-1:0] raw;
   logic [1:0][WIDTH-1:0] mag;
   logic [1:0]            neg;

   assign raw[0] = opa;
   assign raw[1] = opb;

   for (genvar gi = 0; gi < 2; gi++) begin : g_opnd
      assign neg[gi] = signed_mode & raw[gi][WIDTH-1];
      assign mag[gi] = neg[gi] ? (~raw[gi] + ONE_W) : raw[gi];
   end

   assign mag_a = mag[0];
   assign mag_b = mag[1];
   assign neg_a = neg[0];
   assign neg_b = neg[1];

endmodule

// File: rtl/mdu_iter_core.sv
module mdu_iter_core #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic             step,
   input  logic             is_div,
   input  logic [WIDTH-1:0] mag_a,
   input  logic [WIDTH-1:0] mag_b,
   output logic [WIDTH-1:0] acc_hi,
   output logic [WIDTH-1:0] acc_lo
);

   logic [WIDTH-1:0] hi_q, lo_q, opnd_q;
   logic [WIDTH-1:0] hi_n, lo_n;
   logic [WIDTH:0]   mul_sum;
   logic [WIDTH:0]   div_shift;
   logic [WIDTH:0]   div_diff;

   always_comb begin
      mul_sum   = {1'b0, hi_q} + (lo_q[0] ? {1'b0, opnd_q} : '0);
      div_shift = {hi_q, lo_q[WIDTH-1]};
      div_diff  = div_shift - {1'b0, opnd_q};
      if (!is_div) begin
         hi_n = mul_sum[WIDTH:1];
         lo_n = {mul_sum[0], lo_q[WIDTH-1:1]};
      end else if (!div_diff[WIDTH]) begin
         hi_n = div_diff[WIDTH-1:0];
         lo_n = {lo_q[WIDTH-2:0], 1'b1};
      end else begin
         hi_n = div_shift[WIDTH-1:0];
         lo_n = {lo_q[WIDTH-2:0], 1'b0};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q   <= '0;
         lo_q   <= '0;
         opnd_q <= '0;
      end else if (load) begin
         hi_q   <= '0;
         lo_q   <= is_div ? mag_a : mag_b;
         opnd_q <= is_div ? mag_b : mag_a;
      end else if (step) begin
         hi_q <= hi_n;
         lo_q <= lo_n;
      end
   end

   assign acc_hi = hi_q;
   assign acc_lo = lo_q;

endmodule

// File: rtl/mdu_result_fix.sv
module mdu_result_fix #(
   parameter int WIDTH = 32
) (
   input  mdu_pkg::mdu_ctl_t ctl,
   input  logic [WIDTH-1:0]  acc_hi,
   input  logic [WIDTH-1:0]  acc_lo,
   output logic [WIDTH-1:0]  res_hi,
   output logic [WIDTH-1:0]  res_lo
);

   localparam int DW = 2 * WIDTH;
   localparam logic [DW-1:0]    ONE_D = DW'(1);
   localparam logic [WIDTH-1:0] ONE_W = WIDTH'(1);

   logic [DW-1:0]    prod;
   logic [DW-1:0]    prod_fix;
   logic [WIDTH-1:0] quot_fix;
   logic [WIDTH-1:0] rem_fix;

   always_comb begin
      prod     = {acc_hi, acc_lo};
      prod_fix = ctl.neg_main ? (~prod + ONE_D) : prod;
      quot_fix = ctl.neg_main ? (~acc_lo + ONE_W) : acc_lo;
      rem_fix  = ctl.neg_rem ? (~acc_hi + ONE_W) : acc_hi;
      if (!ctl.is_div) begin
         res_hi = prod_fix[DW-1:WIDTH];
         res_lo = prod_fix[WIDTH-1:0];
      end else if (ctl.div_zero) begin
         res_hi = rem_fix;
         res_lo = '1;
      end else begin
         res_hi = rem_fix;
         res_lo = quot_fix;
      end
   end

endmodule

// File: rtl/mdu_hilo.sv
module mdu_hilo #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             op_div_i,
   input  logic             signed_i,
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic             hi_wr_i,
   input  logic             lo_wr_i,
   input  logic [WIDTH-1:0] wdata_i,
   output logic             busy_o,
   output logic             done_o,
   output logic [WIDTH-1:0] hi_o,
   output logic [WIDTH-1:0] lo_o
);

   import mdu_pkg::*;

   localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
   localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

   if (WIDTH < 2) begin : g_bad_width
      $error("mdu_hilo: WIDTH must be at least 2");
   end

   mdu_state_e       state_q;
   logic [CNT_W-1:0] cnt_q;
   mdu_ctl_t         ctl_q, ctl_d;
   logic [WIDTH-1:0] hi_q, lo_q;
   logic             done_q;

   logic [WIDTH-1:0] mag_a, mag_b;
   logic             neg_a, neg_b;
   logic [WIDTH-1:0] acc_hi, acc_lo;
   logic [WIDTH-1:0] res_hi, res_lo;
   logic             idle, accept, stepping;

   assign idle     = (state_q == MDU_IDLE);
   assign accept   = idle & start_i;
   assign stepping = (state_q == MDU_RUN);

   mdu_operand_prep #(.WIDTH(WIDTH)) u_prep (
      .signed_mode (signed_i),
      .opa         (opa_i),
      .opb         (opb_i),
      .mag_a       (mag_a),
      .mag_b       (mag_b),
      .neg_a       (neg_a),
      .neg_b       (neg_b)
   );

   always_comb begin
      ctl_d.is_div   = op_div_i;
      ctl_d.neg_main = neg_a ^ neg_b;
      ctl_d.neg_rem  = neg_a;
      ctl_d.div_zero = op_div_i & (opb_i == '0);
   end

   mdu_iter_core #(.WIDTH(WIDTH)) u_core (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (accept),
      .step   (stepping),
      .is_div (accept ? op_div_i : ctl_q.is_div),
      .mag_a  (mag_a),
      .mag_b  (mag_b),
      .acc_hi (acc_hi),
      .acc_lo (acc_lo)
   );

   mdu_result_fix #(.WIDTH(WIDTH)) u_fix (
      .ctl    (ctl_q),
      .acc_hi (acc_hi),
      .acc_lo (acc_lo),
      .res_hi (res_hi),
      .res_lo (res_lo)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= MDU_IDLE;
         cnt_q   <= '0;
         ctl_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            MDU_IDLE: begin
               if (start_i) begin
                  state_q <= MDU_RUN;
                  cnt_q   <= '0;
                  ctl_q   <= ctl_d;
               end
            end
            MDU_RUN: begin
               cnt_q <= cnt_q + 1'b1;
               if (cnt_q == LAST_STEP) begin
                  state_q <= MDU_FIN;
               end
            end
            MDU_FIN: begin
               state_q <= MDU_IDLE;
               done_q  <= 1'b1;
            end
            default: state_q <= MDU_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_q <= '0;
         lo_q <= '0;
      end else if (state_q == MDU_FIN) begin
         hi_q <= res_hi;
         lo_q <= res_lo;
      end else if (idle) begin
         if (hi_wr_i) hi_q <= wdata_i;
         if (lo_wr_i) lo_q <= wdata_i;
      end
   end

   assign busy_o = !idle;
   assign done_o = done_q;
   assign hi_o   = hi_q;
   assign lo_o   = lo_q;

endmodule

// File: rtl/mdu_hilo_chk.sv
module mdu_hilo_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic             hi_wr_i,
   input logic             lo_wr_i,
   input logic [WIDTH-1:0] wdata_i,
   input logic             busy_o,
   input logic             done_o,
   input logic [WIDTH-1:0] hi_o,
   input logic [WIDTH-1:0] lo_o
);

   int unsigned busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      busy_run <= 0;
      else if (busy_o) busy_run <= busy_run + 1;
      else             busy_run <= 0;
   end

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_busy_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (busy_run == WIDTH + 1));

   assert_idle_with_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);

   assert_restart_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> (busy_o || done_o));

   assert_hold_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> (done_o || ($stable(hi_o) && $stable(lo_o))));

   assert_hi_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && hi_wr_i) |=> (hi_o == $past(wdata_i)));

   assert_lo_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && lo_wr_i) |=> (lo_o == $past(wdata_i)));

   assert_hi_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_o && !start_i && !hi_wr_i) |=> $stable(hi_o));

endmodule

bind mdu_hilo mdu_hilo_chk #(.WIDTH(WIDTH)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .start_i (start_i),
   .hi_wr_i (hi_wr_i),
   .lo_wr_i (lo_wr_i),
   .wdata_i (wdata_i),
   .busy_o  (busy_o),
   .done_o  (done_o),
   .hi_o    (hi_o),
   .lo_o    (lo_o)
);

// File: tb/test_mdu_hilo.sv
module test_mdu_hilo;

   localparam int W          = 32;
   localparam int CLK_PERIOD = 10;
   localparam int LATENCY    = W + 2;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         start_i = 1'b0;
   logic         op_div_i = 1'b0;
   logic         signed_i = 1'b0;
   logic [W-1:0] opa_i = '0;
   logic [W-1:0] opb_i = '0;
   logic         hi_wr_i = 1'b0;
   logic         lo_wr_i = 1'b0;
   logic [W-1:0] wdata_i = '0;
   logic         busy_o, done_o;
   logic [W-1:0] hi_o, lo_o;

   int checks = 0;
   int fails  = 0;
   int unsigned cyc = 0;
   int unsigned seed = 32'h1234_5678;

   typedef struct {
      logic [W-1:0] exp_hi;
      logic [W-1:0] exp_lo;
      logic [W-1:0] old_hi;
      logic [W-1:0] old_lo;
      int unsigned  start_cyc;
      string        req;
   } sb_item_t;

   sb_item_t sb_q[$];
   logic [W-1:0] prev_hi = '0, prev_lo = '0;

   mdu_hilo #(.WIDTH(W)) i_mdu_hilo (
      .clk, .rst_n, .start_i, .op_div_i, .signed_i, .opa_i, .opb_i,
      .hi_wr_i, .lo_wr_i, .wdata_i, .busy_o, .done_o, .hi_o, .lo_o
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input string what,
                        input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   function automatic void model(input logic is_div, input logic sgn,
                                 input logic [W-1:0] a, input logic [W-1:0] b,
                                 output logic [W-1:0] eh, output logic [W-1:0] el);
      longint sa, sb, p, q, r;
      logic [2*W-1:0] up;
      sa = sgn ? longint'($signed(a)) : longint'({32'b0, a});
      sb = sgn ? longint'($signed(b)) : longint'({32'b0, b});
      if (!is_div) begin
         if (sgn) begin
            p = sa * sb;
            {eh, el} = p;
         end else begin
            up = {32'b0, a} * {32'b0, b};
            {eh, el} = up;
         end
      end else if (b == '0) begin
         el = '1;
         eh = a;
      end else begin
         q = sa / sb;
         r = sa % sb;
         el = q[W-1:0];
         eh = r[W-1:0];
      end
   endfunction

   // Monitor: pops the scoreboard on each completion pulse
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         if (sb_q.size() == 0) begin
            check(1'b0, "R7", "unexpected done pulse", {31'b0, done_o}, '0);
         end else begin
            sb_item_t it;
            it = sb_q.pop_front();
            check(hi_o == it.exp_hi, it.req, "HI result", hi_o, it.exp_hi);
            check(lo_o == it.exp_lo, it.req, "LO result", lo_o, it.exp_lo);
            check(cyc - it.start_cyc == LATENCY, "R6", "done latency",
                  W'(cyc - it.start_cyc), W'(LATENCY));
            check(!busy_o, "R6", "busy low with done", {31'b0, busy_o}, '0);
            check(prev_hi == it.old_hi && prev_lo == it.old_lo, "R8",
                  "HI/LO held until done", prev_hi, it.old_hi);
         end
      end
      prev_hi <= hi_o;
      prev_lo <= lo_o;
   end

   // Driver: pushes expected item, pulses start, optionally pokes while busy
   task automatic run_op(input logic is_div, input logic sgn,
                         input logic [W-1:0] a, input logic [W-1:0] b,
                         input string req, input bit poke);
      sb_item_t it;
      int n;
      @(negedge clk);
      model(is_div, sgn, a, b, it.exp_hi, it.exp_lo);
      it.old_hi = hi_o;
      it.old_lo = lo_o;
      it.start_cyc = cyc;
      it.req = req;
      sb_q.push_back(it);
      op_div_i = is_div; signed_i = sgn; opa_i = a; opb_i = b; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (poke) begin
         repeat (4) @(negedge clk);
         // R7 / R10: restart request and direct writes while busy
         start_i = 1'b1; op_div_i = ~is_div; opa_i = ~a; opb_i = b ^ 32'h55;
         hi_wr_i = 1'b1; lo_wr_i = 1'b1; wdata_i = 32'hDEAD_BEEF;
         @(negedge clk);
         start_i = 1'b0; hi_wr_i = 1'b0; lo_wr_i = 1'b0;
         check(hi_o == it.old_hi, "R10", "HI after write while busy", hi_o, it.old_hi);
         check(lo_o == it.old_lo, "R10", "LO after write while busy", lo_o, it.old_lo);
      end
      n = 0;
      while (!done_o && n < 4 * LATENCY) begin
         @(negedge clk);
         n++;
      end
      if (!done_o) check(1'b0, req, "operation timed out", '0, '1);
   endtask

   task automatic direct_write(input bit wh, input bit wl, input logic [W-1:0] d);
      logic [W-1:0] oh, ol, eh, el;
      @(negedge clk);
      oh = hi_o; ol = lo_o;
      eh = wh ? d : oh;
      el = wl ? d : ol;
      hi_wr_i = wh; lo_wr_i = wl; wdata_i = d;
      @(negedge clk);
      hi_wr_i = 1'b0; lo_wr_i = 1'b0;
      check(hi_o == eh, "R9", "HI after direct write", hi_o, eh);
      check(lo_o == el, "R9", "LO after direct write", lo_o, el);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(1'b0, "R6", "watchdog expired", '0, '1);
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R11: reset state
      check(hi_o == '0, "R11", "HI in reset", hi_o, '0);
      check(lo_o == '0, "R11", "LO in reset", lo_o, '0);
      check(!busy_o, "R11", "busy in reset", {31'b0, busy_o}, '0);
      check(!done_o, "R11", "done in reset", {31'b0, done_o}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 unsigned multiply
      run_op(1'b0, 1'b0, 32'd3, 32'd5, "R1", 1'b0);
      run_op(1'b0, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R1", 1'b0);
      run_op(1'b0, 1'b0, 32'h8000_0000, 32'd2, "R1", 1'b0);
      run_op(1'b0, 1'b0, 32'd0, 32'h1357_9BDF, "R1", 1'b0);
      // R2 unsigned divide
      run_op(1'b1, 1'b0, 32'd100, 32'd7, "R2", 1'b0);
      run_op(1'b1, 1'b0, 32'hFFFF_FFFF, 32'd1, "R2", 1'b0);
      run_op(1'b1, 1'b0, 32'd5, 32'd10, "R2", 1'b0);
      run_op(1'b1, 1'b0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R2", 1'b0);
      run_op(1'b1, 1'b0, 32'h8000_0000, 32'h8000_0001, "R2", 1'b0);
      // R3 signed multiply
      run_op(1'b0, 1'b1, -32'sd3, 32'd5, "R3", 1'b0);
      run_op(1'b0, 1'b1, -32'sd7, -32'sd9, "R3", 1'b0);
      run_op(1'b0, 1'b1, 32'h8000_0000, 32'h8000_0000, "R3", 1'b0);
      run_op(1'b0, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, "R3", 1'b0);
      // R4 signed divide
      run_op(1'b1, 1'b1, -32'sd7, 32'd2, "R4", 1'b0);
      run_op(1'b1, 1'b1, 32'd7, -32'sd2, "R4", 1'b0);
      run_op(1'b1, 1'b1, -32'sd7, -32'sd2, "R4", 1'b0);
      run_op(1'b1, 1'b1, 32'h8000_0000, 32'hFFFF_FFFF, "R4", 1'b0);
      // R5 divide by zero
      run_op(1'b1, 1'b0, 32'h0000_1234, 32'd0, "R5", 1'b0);
      run_op(1'b1, 1'b1, -32'sd5, 32'd0, "R5", 1'b0);
      run_op(1'b1, 1'b1, 32'h8000_0000, 32'd0, "R5", 1'b0);
      // R9 direct writes while idle
      direct_write(1'b1, 1'b0, 32'hA5A5_0001);
      direct_write(1'b0, 1'b1, 32'h5A5A_0002);
      direct_write(1'b1, 1'b1, 32'h0F0F_F0F0);
      // R7 / R10: restart and writes while busy are ignored
      run_op(1'b0, 1'b0, 32'h0001_0003, 32'h0002_0005, "R7", 1'b1);
      run_op(1'b1, 1'b1, -32'sd1000, 32'd33, "R7", 1'b1);
      repeat (2 * LATENCY) @(negedge clk);
      check(sb_q.size() == 0 && !busy_o, "R7", "no extra operation started",
            {31'b0, busy_o}, '0);
      // Mixed operations
      for (int k = 0; k < 24; k++) begin
         logic [W-1:0] ra, rb;
         seed = seed * 32'd1103515245 + 32'd12345; ra = seed;
         seed = seed * 32'd1103515245 + 32'd12345; rb = seed;
         if (k % 5 == 4) rb = rb >> 20;
         run_op(k[0], k[1], ra, rb, k[0] ? (k[1] ? "R4" : "R2") : (k[1] ? "R3" : "R1"), 1'b0);
      end
      repeat (4) @(negedge clk);
      finish_run();
   end

endmodule